// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a byte-wide nonvolatile array and watches the write cycles issued by a host. Every cycle is an address and a data byte, presented for one clock with a strobe. The block recognises multi-cycle unlock sequences. Each sequence starts with the same two-cycle prefix. A third cycle either completes a short command or leads into a second prefix and a sixth cycle that completes a long command. The block keeps one global write-protection flag and an identification mode flag. It produces a page-load window and a one-cycle erase start for the array control that follows it.

While protection is set, a plain data write that was not preceded by the unlock prefix is discarded, and for a programmable number of cycles afterwards the block ignores every write. While the identification flag is set, the read port returns a manufacturer byte or a device byte for the two lowest addresses. Consecutive cycles of a sequence, and consecutive bytes of a page load, must each come within a programmable window of cycles. If a gap exceeds the window, the sequence is abandoned or the page load closes.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, prot_en, id_mode, page_load_en, data_accept, erase_start, locked and id_hit are all 0.
- R2: The cycles AAh at 5555h, 55h at 2AAAh, A0h at 5555h set prot_en to 1 and open the page-load window (page_load_en=1) in the cycle after the third write.
- R3: While the page-load window is open, each write produces a one-cycle data_accept pulse in the cycle after it and restarts the window. The window closes (page_load_en=0) when WIN_CYC cycles pass without a write.
- R4: With prot_en=1 and no window or sequence in progress, a write other than AAh at 5555h gives no data_accept and raises locked for LOCK_CYC cycles. A write sampled while locked is 1 is ignored.
- R5: The six cycles AA/55/80/AA/55/20 (at 5555h, 2AAAh, 5555h, 5555h, 2AAAh, 5555h) clear prot_en.
- R6: The six cycles AA/55/80/AA/55/10 at those addresses produce erase_start high for exactly one cycle.
- R7: A third cycle of 90h at 5555h, or the six cycles ending in 60h, set id_mode. A third cycle of F0h at 5555h clears id_mode.
- R8: With id_mode=1 and rd_addr[14:1]=0, id_hit=1 and id_byte is BFh for rd_addr[0]=0 and DEV_CODE for rd_addr[0]=1. Any other rd_addr gives id_hit=0.
- R9: Only wr_addr[14:0] takes part in matching. Bits 16 and 15 have no effect.
- R10: A cycle that breaks a sequence returns the decoder to idle without being taken as the first cycle of a new sequence.
- R11: A sequence continues when the next cycle comes at most WIN_CYC cycles after the previous one and is abandoned when the gap is WIN_CYC+1.
- R12: With prot_en=0, a plain write from idle is accepted (data_accept=1) and opens the page-load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One write cycle per clock while high |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| rd_addr | input | ADDR_W | Read address for identification bytes |
| page_load_en | output | 1 | Page-load window open |
| data_accept | output | 1 | Pulse: last write taken as page data |
| erase_start | output | 1 | Pulse: chip erase requested |
| prot_en | output | 1 | Global write protection set |
| id_mode | output | 1 | Identification mode active |
| locked | output | 1 | Writes are being ignored after a discarded write |
| id_hit | output | 1 | rd_addr selects an identification byte |
| id_byte | output | 8 | Identification byte, 0 when id_hit=0 |

## Verification
The bench builds the block with WIN_CYC=8 and LOCK_CYC=12 instead of the tens of thousands of cycles that microsecond-scale limits would need. With these values, both sides of each boundary can be reached in a few cycles: a gap of exactly the window against one cycle more, and the last ignored write of a lockout against the first accepted one. DEV_CODE stays at its default, so the device byte read in identification mode is known.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;

    localparam logic [7:0] OP_PROTECT = 8'hA0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_ID_IN   = 8'h90;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] OP_UNPROT  = 8'h20;
    localparam logic [7:0] OP_WIPE    = 8'h10;
    localparam logic [7:0] OP_ID_ALT  = 8'h60;

    localparam logic [7:0] MFR_CODE = 8'hBF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE1,
        ST_PRE2,
        ST_EXT,
        ST_EXT_PRE1,
        ST_EXT_PRE2,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       prot;
        logic       idm;
        logic       acc;
        logic       ers;
    } dec_regs_t;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              at_key_a,
    output logic              first_ok,
    output logic              second_ok
);
    logic [CMP_W-1:0] low_addr;

    always_comb begin
        low_addr  = addr[CMP_W-1:0];
        at_key_a  = (low_addr == KEY_ADDR_A);
        first_ok  = at_key_a && (data == KEY_DATA_A);
        second_ok = (low_addr == KEY_ADDR_B) && (data == KEY_DATA_B);
    end

endmodule

// File: rtl/span_timer.sv
module span_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        busy   = (cnt_q != '0);
        expire = (cnt_q == CW'(1)) && !start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/id_readout.sv
module id_readout
    import unlock_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] DEV_CODE = 8'h07
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_hit,
    output logic [7:0]        id_byte
);
    always_comb begin
        id_hit  = id_mode && (rd_addr[CMP_W-1:1] == '0);
        id_byte = 8'h00;
        if (id_hit) begin
            id_byte = rd_addr[0] ? DEV_CODE : MFR_CODE;
        end
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import unlock_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         WIN_CYC  = 5000,
    parameter int         LOCK_CYC = 15000,
    parameter logic [7:0] DEV_CODE = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              page_load_en,
    output logic              data_accept,
    output logic              erase_start,
    output logic              prot_en,
    output logic              id_mode,
    output logic              locked,
    output logic              id_hit,
    output logic [7:0]        id_byte
);
    dec_regs_t r_d, r_q;

    logic at_key_a, first_ok, second_ok;
    logic win_start, win_busy, win_expire;
    logic lock_start, lock_busy, lock_expire;

    cmd_match #(.ADDR_W(ADDR_W)) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .at_key_a  (at_key_a),
        .first_ok  (first_ok),
        .second_ok (second_ok)
    );

    span_timer #(.LIMIT(WIN_CYC)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (win_start),
        .busy   (win_busy),
        .expire (win_expire)
    );

    span_timer #(.LIMIT(LOCK_CYC)) u_lockout (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (lock_start),
        .busy   (lock_busy),
        .expire (lock_expire)
    );

    id_readout #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode (r_q.idm),
        .rd_addr (rd_addr),
        .id_hit  (id_hit),
        .id_byte (id_byte)
    );

    always_comb begin
        r_d        = r_q;
        r_d.acc    = 1'b0;
        r_d.ers    = 1'b0;
        win_start  = 1'b0;
        lock_start = 1'b0;

        if (wr_stb && !lock_busy) begin
            r_d.st = ST_IDLE;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (first_ok) begin
                        r_d.st    = ST_PRE1;
                        win_start = 1'b1;
                    end else if (r_q.prot) begin
                        lock_start = 1'b1;
                    end else begin
                        r_d.st    = ST_LOAD;
                        r_d.acc   = 1'b1;
                        win_start = 1'b1;
                    end
                end
                ST_PRE1: begin
                    if (second_ok) begin
                        r_d.st    = ST_PRE2;
                        win_start = 1'b1;
                    end
                end
                ST_PRE2: begin
                    if (at_key_a) begin
                        unique case (wr_data)
                            OP_PROTECT: begin
                                r_d.prot  = 1'b1;
                                r_d.st    = ST_LOAD;
                                win_start = 1'b1;
                            end
                            OP_EXTEND: begin
                                r_d.st    = ST_EXT;
                                win_start = 1'b1;
                            end
                            OP_ID_IN:  r_d.idm = 1'b1;
                            OP_ID_OUT: r_d.idm = 1'b0;
                            default:   r_d.st  = ST_IDLE;
                        endcase
                    end
                end
                ST_EXT: begin
                    if (first_ok) begin
                        r_d.st    = ST_EXT_PRE1;
                        win_start = 1'b1;
                    end
                end
                ST_EXT_PRE1: begin
                    if (second_ok) begin
                        r_d.st    = ST_EXT_PRE2;
                        win_start = 1'b1;
                    end
                end
                ST_EXT_PRE2: begin
                    if (at_key_a) begin
                        unique case (wr_data)
                            OP_UNPROT: r_d.prot = 1'b0;
                            OP_WIPE:   r_d.ers  = 1'b1;
                            OP_ID_ALT: r_d.idm  = 1'b1;
                            default:   r_d.st   = ST_IDLE;
                        endcase
                    end
                end
                ST_LOAD: begin
                    r_d.st    = ST_LOAD;
                    r_d.acc   = 1'b1;
                    win_start = 1'b1;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end else if (r_q.st != ST_IDLE && win_expire) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, prot: 1'b0, idm: 1'b0, acc: 1'b0, ers: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign page_load_en = (r_q.st == ST_LOAD);
    assign data_accept  = r_q.acc;
    assign erase_start  = r_q.ers;
    assign prot_en      = r_q.prot;
    assign id_mode      = r_q.idm;
    assign locked       = lock_busy;

    // R2
    prot_rise_opens_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> page_load_en);

    // R3
    load_close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(page_load_en) |-> !$past(wr_stb));

    // R4
    locked_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_stb) |=> !data_accept);

    // R6
    erase_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R7
    id_rise_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(wr_stb));

endmodule

// File: tb/sim_unlock_cmd_decoder.sv
module sim_unlock_cmd_decoder;
    localparam int WIN = 8;
    localparam int LCK = 12;
    localparam int NV  = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [16:0] rd_addr = '0;
    logic page_load_en, data_accept, erase_start, prot_en, id_mode, locked, id_hit;
    logic [7:0] id_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(17), .WIN_CYC(WIN), .LOCK_CYC(LCK), .DEV_CODE(8'h07)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .page_load_en(page_load_en), .data_accept(data_accept),
        .erase_start(erase_start), .prot_en(prot_en), .id_mode(id_mode), .locked(locked),
        .id_hit(id_hit), .id_byte(id_byte)
    );

    // {pre idle cycles, addr, data, expected {prot, load, accept, erase, id, locked}}
    localparam logic [38:0] VEC [0:NV-1] = '{
        {8'd0,  17'h05555, 8'hAA, 6'b000000},  // R2 prefix
        {8'd0,  17'h02AAA, 8'h55, 6'b000000},
        {8'd0,  17'h05555, 8'hA0, 6'b110000},  // R2
        {8'd0,  17'h00100, 8'h12, 6'b111000},  // R3
        {8'd2,  17'h00101, 8'h34, 6'b111000},  // R3
        {8'd10, 17'h00200, 8'h56, 6'b100001},  // R3 closed, R4 discard
        {8'd14, 17'h1D555, 8'hAA, 6'b100000},  // R9 high bits ignored
        {8'd0,  17'h0AAAA, 8'h55, 6'b100000},  // R9
        {8'd0,  17'h05555, 8'h80, 6'b100000},
        {8'd0,  17'h05555, 8'hAA, 6'b100000},
        {8'd0,  17'h02AAA, 8'h55, 6'b100000},
        {8'd0,  17'h05555, 8'h10, 6'b100100},  // R6
        {8'd0,  17'h05555, 8'hAA, 6'b100000},
        {8'd0,  17'h02AAA, 8'h55, 6'b100000},
        {8'd0,  17'h05555, 8'h90, 6'b100010},  // R7 entry
        {8'd0,  17'h05555, 8'hAA, 6'b100010},
        {8'd0,  17'h02AAA, 8'h55, 6'b100010},
        {8'd0,  17'h05555, 8'hF0, 6'b100000},  // R7 exit
        {8'd0,  17'h05555, 8'hAA, 6'b100000},
        {8'd0,  17'h02AAA, 8'h55, 6'b100000},
        {8'd0,  17'h05555, 8'h80, 6'b100000},
        {8'd0,  17'h05555, 8'hAA, 6'b100000},
        {8'd0,  17'h02AAA, 8'h55, 6'b100000},
        {8'd0,  17'h05555, 8'h20, 6'b000000},  // R5
        {8'd0,  17'h00300, 8'h77, 6'b011000},  // R12
        {8'd10, 17'h05555, 8'hAA, 6'b000000},
        {8'd0,  17'h05555, 8'hAA, 6'b000000},  // R10 break
        {8'd0,  17'h02AAA, 8'h55, 6'b011000},  // R10 no restart
        {8'd0,  17'h05555, 8'hA0, 6'b011000}   // R10 prot stays 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int pre, input logic [16:0] a, input logic [7:0] d);
        repeat (pre) @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    function automatic logic [5:0] outs();
        return {prot_en, page_load_en, data_accept, erase_start, id_mode, locked};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {25'd0, outs(), id_hit}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {25'd0, outs(), id_hit}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            put(int'(VEC[i][38:31]), VEC[i][30:14], VEC[i][13:6]);
            check($sformatf("R2-vector %0d", i), {26'd0, outs()}, {26'd0, VEC[i][5:0]});
        end

        // R11: gap of WIN+1 abandons the sequence
        put(10, 17'h05555, 8'hAA);
        put(WIN - 1, 17'h02AAA, 8'h55);
        put(WIN, 17'h05555, 8'hA0);
        check("R11 late cycle", {31'd0, prot_en}, 32'd0);
        // R11: gap of exactly WIN keeps it
        put(10, 17'h05555, 8'hAA);
        put(WIN - 1, 17'h02AAA, 8'h55);
        put(WIN - 1, 17'h05555, 8'hA0);
        check("R11 on-time cycle", {30'd0, prot_en, page_load_en}, 32'd3);

        // R7 long entry form, R8 reads
        put(10, 17'h05555, 8'hAA);
        put(0, 17'h02AAA, 8'h55);
        put(0, 17'h05555, 8'h80);
        put(0, 17'h05555, 8'hAA);
        put(0, 17'h02AAA, 8'h55);
        put(0, 17'h05555, 8'h60);
        check("R7 alternate entry", {31'd0, id_mode}, 32'd1);
        rd_addr = 17'h00000; #1;
        check("R8 manufacturer byte", {23'd0, id_hit, id_byte}, {23'd0, 1'b1, 8'hBF});
        rd_addr = 17'h00001; #1;
        check("R8 device byte", {23'd0, id_hit, id_byte}, {23'd0, 1'b1, 8'h07});
        rd_addr = 17'h00002; #1;
        check("R8 other address", {23'd0, id_hit, id_byte}, 32'd0);
        put(0, 17'h05555, 8'hAA);
        put(0, 17'h02AAA, 8'h55);
        put(0, 17'h05555, 8'hF0);
        rd_addr = 17'h00000; #1;
        check("R7 exit clears read", {30'd0, id_mode, id_hit}, 32'd0);

        // R4 lockout length: protection is set here
        put(0, 17'h00000, 8'h11);
        check("R4 discard", {30'd0, data_accept, locked}, 32'd1);
        put(LCK - 1, 17'h05555, 8'hAA);
        check("R4 last ignored write", {30'd0, data_accept, locked}, 32'd0);
        put(0, 17'h05555, 8'hAA);
        put(0, 17'h02AAA, 8'h55);
        put(0, 17'h05555, 8'hA0);
        check("R4 write after lockout", {30'd0, page_load_en, locked}, 32'd2);

        // R1 reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears state", {25'd0, outs(), id_hit}, 32'd0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        end
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule